// File: doc/BRIEF.md
# Three-Pin Bidirectional Port with Direction and Data Registers

This block is a small memory-mapped general-purpose port. It serves three physical pins. Two 8-bit registers sit behind a simple register bus. The direction register sets, pin by pin, whether the pin drives (bit = 1) or listens (bit = 0). The data register holds the values that driving pins put out. Only the low three bits of each register are stored. The five upper bits are reserved: writes to them are dropped and they always read back as ones. Pin inputs pass through a two-stage synchronizer before they are used for readback.

A serial peripheral can take over selected pins through an override interface. A small ownership state machine decides when the override is in force. The override replaces the pin drive signals but never alters register contents.

Two standby inputs act on the block:
- Hardware standby reloads both registers to their reset image 0xF8 and drops the override. It wins over register writes and over software standby.
- Software standby keeps both registers as they are. It revokes the peripheral's ownership of the pins.

The ownership machine has three states:
- **IDLE**: the registers control the pins.
- **OWNED**: the peripheral controls the pins selected by its mask.
- **LOCKOUT**: ownership was revoked by software standby. The machine waits here for the claim and software standby both to go low.

Its transitions are:
- **grant** (IDLE→OWNED): claim high, no software standby.
- **yield** (OWNED→IDLE): claim dropped.
- **revoke** (OWNED→LOCKOUT): software standby high while owned.
- **rearm** (LOCKOUT→IDLE): claim low and software standby low.
- **hw_clear** (any state→IDLE): hardware standby.

Top module: `pio_trio_port`

## Requirements
- R1: With no override in force, `pin_oe[i]` equals the stored direction bit i and `pin_do[i]` equals the stored data bit i.
- R2: A read (`bus_cs` and `bus_re` high) at address 0, the direction register, returns 0xFF whatever is stored.
- R3: Asynchronous reset (`rst_n` low) loads 0xF8 into both registers, so the stored low three bits are 000. Each clock edge with `hw_stby` high does the same.
- R4: While `sw_stby` is high and no write or hardware standby occurs, both registers keep their contents. A pin set as output keeps driving its data bit.
- R5: A read at address 1, the data register, returns in bit i (i < 3) the stored data bit when direction bit i is 1. When direction bit i is 0 it returns the synchronized pin level. This holds even for pins under peripheral override.
- R6: A change on `pin_in` appears in readback after exactly two rising clock edges.
- R7: Register bits 7 to 3 ignore written values and read as 1 on every selected read.
- R8: While `per_active` is 1, pins whose `per_mask` bit is 1 take `per_oe`/`per_do` instead of the register-derived values. Register contents are unchanged.
- R9: A claim raised in IDLE with `sw_stby` low sets `per_active` at the next edge. Dropping the claim clears it at the next edge.
- R10: `sw_stby` high while OWNED clears `per_active` at the next edge. Ownership is not granted again until the claim has been low with `sw_stby` low for at least one edge.
- R11: `hw_stby` takes priority over a register write and over `sw_stby` in the same cycle. It also clears `per_active` at the next edge.
- R12: A register write happens on the rising edge only when `bus_cs` and `bus_we` are both high. Address 0 writes the direction register and address 1 writes the data register.
- R13: `bus_rdata` is 0x00 whenever `bus_cs` and `bus_re` are not both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby: reload registers, drop override |
| sw_stby | input | 1 | Software standby: keep registers, revoke override |
| bus_cs | input | 1 | Register bus chip select |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_addr | input | 1 | 0 = direction register, 1 = data register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_in | input | 3 | Raw pin levels (asynchronous) |
| pin_oe | output | 3 | Pin output enable |
| pin_do | output | 3 | Pin output value |
| per_claim | input | 1 | Peripheral requests pin ownership |
| per_mask | input | 3 | Pins the peripheral takes over |
| per_oe | input | 3 | Peripheral output enables |
| per_do | input | 3 | Peripheral output values |
| per_active | output | 1 | Override in force (state OWNED) |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- **Direction register read.** A design that returned the stored bits instead of all ones would show 0xFD-style values.
- **Reserved write bits.** Written ones would leak into the pin drive if the design kept them.
- **Readback on input pins.** A design that skipped a synchronizer stage would show the new level one edge early.
- **Peripheral pins on readback.** A design that read the peripheral's value back would break the data-register rule.
- **Software standby with the claim still high.** A missing LOCKOUT state would grant ownership again immediately.
- **Hardware standby in the same cycle as a write and software standby.** A wrong priority would leave written bits in place.

// File: rtl/pio_trio_pkg.sv
package pio_trio_pkg;
    typedef enum logic [1:0] {
        OV_IDLE    = 2'd0,
        OV_OWNED   = 2'd1,
        OV_LOCKOUT = 2'd2
    } ov_state_t;

    localparam logic ADDR_DIR = 1'b0;
    localparam logic ADDR_DAT = 1'b1;
endpackage

// File: rtl/pio_sync2.sv
module pio_sync2 #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;

    // R6: the synchronized value is the raw input from two edges back
    assert_two_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |=> d_sync == $past(d_async, 2));
endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
    import pio_trio_pkg::*;
#(
    parameter int unsigned       PIN_N   = 3,
    parameter int unsigned       REG_W   = 8,
    parameter logic [REG_W-1:0]  RST_VAL = 8'hF8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_stby,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output logic [PIN_N-1:0] dir_q,
    output logic [PIN_N-1:0] dat_q
);
    localparam logic [PIN_N-1:0] LOW_RST = RST_VAL[PIN_N-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= LOW_RST;
            dat_q <= LOW_RST;
        end else if (hw_stby) begin
            dir_q <= LOW_RST;
            dat_q <= LOW_RST;
        end else if (wr_en) begin
            if (wr_addr == ADDR_DIR) dir_q <= wr_data[PIN_N-1:0];
            else                     dat_q <= wr_data[PIN_N-1:0];
        end
    end

    // R3, R11: hardware standby reloads both registers regardless of a write
    assert_hw_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (dir_q == LOW_RST) && (dat_q == LOW_RST));

    // R4, R12: without a write or hardware standby nothing changes
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_stby && !wr_en) |=> $stable(dir_q) && $stable(dat_q));
endmodule

// File: rtl/pio_override_fsm.sv
module pio_override_fsm
    import pio_trio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_stby,
    input  logic sw_stby,
    input  logic claim,
    output logic active
);
    ov_state_t state_q;
    ov_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (hw_stby) begin
            state_d = OV_IDLE;                               // hw_clear
        end else begin
            unique case (state_q)
                OV_IDLE:    if (claim && !sw_stby) state_d = OV_OWNED;  // grant
                OV_OWNED:   if (sw_stby)           state_d = OV_LOCKOUT; // revoke
                            else if (!claim)       state_d = OV_IDLE;    // yield
                OV_LOCKOUT: if (!claim && !sw_stby) state_d = OV_IDLE;   // rearm
                default:    state_d = OV_IDLE;
            endcase
        end
    end

    always_comb begin
        active = (state_q == OV_OWNED);
    end

    // R10: software standby revokes ownership at the next edge
    assert_revoke_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stby |=> !active);

    // R10: after a revoke, a held claim is not granted again
    assert_lockout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OV_LOCKOUT && claim) |=> !active);

    // R11: hardware standby returns the machine to IDLE
    assert_hw_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> state_q == OV_IDLE);
endmodule

// File: rtl/pio_trio_port.sv
module pio_trio_port
    import pio_trio_pkg::*;
#(
    parameter int unsigned      PIN_N   = 3,
    parameter int unsigned      REG_W   = 8,
    parameter logic [REG_W-1:0] RST_VAL = 8'hF8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_stby,
    input  logic             sw_stby,
    input  logic             bus_cs,
    input  logic             bus_we,
    input  logic             bus_re,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [PIN_N-1:0] pin_in,
    output logic [PIN_N-1:0] pin_oe,
    output logic [PIN_N-1:0] pin_do,
    input  logic             per_claim,
    input  logic [PIN_N-1:0] per_mask,
    input  logic [PIN_N-1:0] per_oe,
    input  logic [PIN_N-1:0] per_do,
    output logic             per_active
);
    localparam int unsigned RSV_W = REG_W - PIN_N;

    logic [PIN_N-1:0] dir_q;
    logic [PIN_N-1:0] dat_q;
    logic [PIN_N-1:0] pin_sync;
    logic [PIN_N-1:0] rd_bits;
    logic             wr_en;
    logic             rd_en;

    assign wr_en = bus_cs && bus_we;
    assign rd_en = bus_cs && bus_re;

    pio_sync2 #(.W(PIN_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .d_sync  (pin_sync)
    );

    pio_regfile #(.PIN_N(PIN_N), .REG_W(REG_W), .RST_VAL(RST_VAL)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_stby (hw_stby),
        .wr_en   (wr_en),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .dir_q   (dir_q),
        .dat_q   (dat_q)
    );

    pio_override_fsm u_own (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_stby (hw_stby),
        .sw_stby (sw_stby),
        .claim   (per_claim),
        .active  (per_active)
    );

    for (genvar i = 0; i < PIN_N; i++) begin : g_pin
        always_comb begin
            rd_bits[i] = dir_q[i] ? dat_q[i] : pin_sync[i];
            if (per_active && per_mask[i]) begin
                pin_oe[i] = per_oe[i];
                pin_do[i] = per_do[i];
            end else begin
                pin_oe[i] = dir_q[i];
                pin_do[i] = dat_q[i];
            end
        end
    end

    always_comb begin
        if (!rd_en)                    bus_rdata = '0;
        else if (bus_addr == ADDR_DIR) bus_rdata = '1;
        else                           bus_rdata = {{RSV_W{1'b1}}, rd_bits};
    end

    // R7: reserved bits always read back as ones
    assert_reserved_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> &bus_rdata[REG_W-1:PIN_N]);

    // R8: overridden pins follow the peripheral
    assert_override_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        per_active |-> (((pin_oe ^ per_oe) | (pin_do ^ per_do)) & per_mask) == '0);

    // R1: unselected or un-owned pins follow the registers
    assert_reg_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !per_active |-> (pin_oe == dir_q) && (pin_do == dat_q));
endmodule

// File: tb/pio_trio_port_tb.sv
`timescale 1ns/1ps
module pio_trio_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_stby = 1'b0, sw_stby = 1'b0;
    logic       bus_cs = 1'b0, bus_we = 1'b0, bus_re = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [2:0] pin_in = 3'b000;
    logic [2:0] pin_oe, pin_do;
    logic       per_claim = 1'b0;
    logic [2:0] per_mask = 3'b000, per_oe = 3'b000, per_do = 3'b000;
    logic       per_active;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pio_trio_port dut_i (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .bus_cs(bus_cs), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_do(pin_do),
        .per_claim(per_claim), .per_mask(per_mask), .per_oe(per_oe),
        .per_do(per_do), .per_active(per_active)
    );

    // Behavioural reference model
    logic [2:0] m_dir = 3'b000, m_dat = 3'b000;
    logic [2:0] m_pipe [$] = '{3'b000, 3'b000};
    int         m_own = 0;   // 0 free, 1 peripheral holds pins, 2 waiting for release

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dir = 3'b000; m_dat = 3'b000; m_own = 0;
            m_pipe = '{3'b000, 3'b000};
        end else begin
            m_pipe.push_back(pin_in);
            void'(m_pipe.pop_front());
            if (hw_stby) begin
                m_dir = 3'b000; m_dat = 3'b000; m_own = 0;
            end else begin
                if (bus_cs && bus_we) begin
                    if (bus_addr) m_dat = bus_wdata[2:0];
                    else          m_dir = bus_wdata[2:0];
                end
                if (m_own == 0) begin
                    if (per_claim && !sw_stby) m_own = 1;
                end else if (m_own == 1) begin
                    if (sw_stby) m_own = 2;
                    else if (!per_claim) m_own = 0;
                end else begin
                    if (!per_claim && !sw_stby) m_own = 0;
                end
            end
        end
    end

    function automatic logic [7:0] exp_rdata();
        logic [2:0] mix;
        if (!(bus_cs && bus_re)) return 8'h00;
        if (!bus_addr) return 8'hFF;
        for (int i = 0; i < 3; i++) mix[i] = m_dir[i] ? m_dat[i] : m_pipe[0][i];
        return {5'b11111, mix};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [2:0] eoe, edo;
            for (int i = 0; i < 3; i++) begin
                if (m_own == 1 && per_mask[i]) begin eoe[i] = per_oe[i]; edo[i] = per_do[i]; end
                else begin eoe[i] = m_dir[i]; edo[i] = m_dat[i]; end
            end
            chk("R1/R8 pin_oe", {5'd0, pin_oe}, {5'd0, eoe});
            chk("R1/R8 pin_do", {5'd0, pin_do}, {5'd0, edo});
            chk("R9/R10 per_active", {7'd0, per_active}, {7'd0, m_own == 1});
            chk("R5/R13 rdata", bus_rdata, exp_rdata());
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 5000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<5000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic a, logic [7:0] d);
        bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_cs = 0; bus_we = 0;
    endtask

    task automatic rd_sel(logic a);
        bus_cs = 1; bus_re = 1; bus_addr = a;
        #0.1;
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(2);
        // R3: reset image
        rd_sel(1);
        chk("R3 data reset read", bus_rdata, 8'hF8);
        chk("R3 oe after reset", {5'd0, pin_oe}, 8'h00);
        rd_sel(0);
        chk("R2 dir read", bus_rdata, 8'hFF);
        bus_re = 0; #0.1;
        chk("R13 idle rdata", bus_rdata, 8'h00);
        bus_cs = 0;

        // R12, R7: write direction with reserved ones, data
        wr(0, 8'hFD);
        wr(1, 8'h1A);
        chk("R1 oe", {5'd0, pin_oe}, 8'h05);
        chk("R7 reserved write dropped", {5'd0, pin_do}, 8'h02);
        rd_sel(0);
        chk("R2 dir read after write", bus_rdata, 8'hFF);

        // R5, R6: mixed readback and synchronizer latency
        pin_in = 3'b111;
        rd_sel(1);
        step();
        chk("R6 one edge still old", bus_rdata, 8'hF8);
        step();
        chk("R5 mixed readback", bus_rdata, 8'hFA);
        pin_in = 3'b000;
        step();
        chk("R6 one edge still old", bus_rdata, 8'hFA);
        step();
        chk("R6 two edges new", bus_rdata, 8'hF8);

        // R12: write without chip select has no effect
        bus_cs = 0; bus_re = 0; bus_we = 1; bus_addr = 0; bus_wdata = 8'h00;
        step();
        bus_we = 0;
        chk("R12 no cs write", {5'd0, pin_oe}, 8'h05);

        // R8, R9: peripheral override
        per_mask = 3'b011; per_oe = 3'b011; per_do = 3'b001; per_claim = 1;
        step();
        chk("R9 grant", {7'd0, per_active}, 8'h01);
        chk("R8 override oe", {5'd0, pin_oe}, 8'h07);
        chk("R8 override do", {5'd0, pin_do}, 8'h01);
        pin_in = 3'b001;
        rd_sel(1);
        step(2);
        chk("R5 readback under override", bus_rdata, 8'hF8);
        bus_cs = 0; bus_re = 0;

        // R10, R4: software standby revokes and holds registers
        sw_stby = 1;
        step();
        chk("R10 revoke", {7'd0, per_active}, 8'h00);
        chk("R4 oe kept", {5'd0, pin_oe}, 8'h05);
        chk("R4 do kept", {5'd0, pin_do}, 8'h02);
        step(3);
        sw_stby = 0;
        step(2);
        chk("R10 lockout with held claim", {7'd0, per_active}, 8'h00);
        per_claim = 0;
        step();
        per_claim = 1;
        step();
        chk("R9 regrant after rearm", {7'd0, per_active}, 8'h01);
        per_claim = 0;
        step();
        chk("R9 yield", {7'd0, per_active}, 8'h00);

        // R11: hardware standby beats write and software standby
        per_claim = 1;
        step();
        hw_stby = 1; sw_stby = 1;
        bus_cs = 1; bus_we = 1; bus_addr = 0; bus_wdata = 8'h07;
        step();
        bus_cs = 0; bus_we = 0; sw_stby = 0; per_claim = 0;
        chk("R11 write lost", {5'd0, pin_oe}, 8'h00);
        chk("R11 override cleared", {7'd0, per_active}, 8'h00);
        hw_stby = 0;
        rd_sel(1);
        step(2);
        chk("R3 hw standby image", bus_rdata, 8'hF9);

        bus_cs = 0; bus_re = 0;
        step(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule